// File: doc/BRIEF.md
# Dual Parallel Port with Direction Control and Counter Register Pairs

This block is a register file on an 8-bit processor bus. It gives software two 8-bit bidirectional pin groups, called port A and port B. Each port has an output register and a direction register, and every pin can be an input or an output on its own. When a port is read, bits configured as outputs return what was last written to them. Bits configured as inputs return the level on the pin.

The same 16-entry register space also carries two 16-bit down-counters. A counter is loaded through a low-byte latch plus a write to its high byte, and it then counts down on every clock. The first counter also keeps a readable 16-bit latch. The entries reserved for interrupt, shift and control functions are placeholders only.

A bus access is one clock cycle. `sel` is the chip select. `rd_nwr` high means a read and low means a write. A write takes effect at the clock edge. Read data is combinational from the current state.

Top module: `pia_dual_port`

## Requirements
- R1: While `rst_n` is low and after it, until written, both output registers and both direction registers are zero: `pa_out`, `pa_oe`, `pb_out` and `pb_oe` are all 0. Both counters and the counter latches are also zero.
- R2: A write to register 0 sets the port B output register, and a write to register 1 sets the port A output register. The new value appears on `pb_out` / `pa_out` from the next cycle.
- R3: Register 2 is the port B direction register and register 3 is the port A direction register. Both are readable. Bit value 1 makes the pin an output, and `pb_oe` / `pa_oe` equal these registers.
- R4: A read of register 0 (port B) or register 1 (port A) returns, bit by bit, the output register where the direction bit is 1 and the pin input where it is 0.
- R5: Register 15 behaves exactly as register 1 on both read and write.
- R6: Writes to register 4 or register 6 set counter 1's low latch byte, and a read of register 6 returns that byte. Register 7 writes and reads counter 1's high latch byte, and a write to it leaves the counter unchanged.
- R7: A write of value H to register 5 loads counter 1 with {H, low latch} and also sets the high latch to H. Reads of register 4 and register 5 return counter 1's low and high bytes.
- R8: Each counter decrements by one every clock cycle and wraps from 0x0000 to 0xFFFF. A load in a cycle takes priority over the decrement in that cycle, so the loaded value is read in the next cycle and the value minus one in the cycle after.
- R9: Counter 2 works in the same way: register 8 writes its low latch and reads its low counter byte, and register 9 loads it with {written byte, low latch} and reads its high counter byte.
- R10: Registers 10 to 14 read as 0x00, and writes to them change no port output, direction or counter state.
- R11: `rdata` is 0x00 whenever `sel` is low or the access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select, active high |
| rd_nwr | input | 1 | 1 = read access, 0 = write access |
| rs | input | 4 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output register |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output register |
| pb_oe | output | 8 | Port B per-pin output enable |

## Verification
A counter load and the free-running decrement land on the same clock edge whenever a high-byte counter register is written, because the counter never stops. The bench writes register 5 and register 9 at arbitrary points of the count, including a load of zero that must wrap on the next step. It then reads the low and high counter bytes in the following cycles. A load result minus one, or a value one cycle late, shows a wrong priority. A reference model in the bench applies the load-wins rule every cycle, and this is compared on each random access.

// File: rtl/pia_pkg.sv
package pia_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SEL_W  = 4;

    localparam logic [SEL_W-1:0] RS_PB      = 4'd0;
    localparam logic [SEL_W-1:0] RS_PA      = 4'd1;
    localparam logic [SEL_W-1:0] RS_DIRB    = 4'd2;
    localparam logic [SEL_W-1:0] RS_DIRA    = 4'd3;
    localparam logic [SEL_W-1:0] RS_C1_LO   = 4'd4;
    localparam logic [SEL_W-1:0] RS_C1_HI   = 4'd5;
    localparam logic [SEL_W-1:0] RS_C1_LLO  = 4'd6;
    localparam logic [SEL_W-1:0] RS_C1_LHI  = 4'd7;
    localparam logic [SEL_W-1:0] RS_C2_LO   = 4'd8;
    localparam logic [SEL_W-1:0] RS_C2_HI   = 4'd9;
    localparam logic [SEL_W-1:0] RS_PA_ALT  = 4'd15;

    // Counter read selector: bit 1 picks latch vs counter, bit 0 picks high byte
    typedef enum logic [1:0] {
        CSEL_CNT_LO = 2'b00,
        CSEL_CNT_HI = 2'b01,
        CSEL_LAT_LO = 2'b10,
        CSEL_LAT_HI = 2'b11
    } csel_e;
endpackage

// File: rtl/pia_port.sv
module pia_port #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_out,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] out_o,
    output logic [W-1:0] oe_o,
    output logic [W-1:0] rd_o
);
    typedef struct packed {
        logic [W-1:0] outr;
        logic [W-1:0] dir;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_out) st_d.outr = wdata;
        if (wr_dir) st_d.dir  = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o = st_q.outr;
    assign oe_o  = st_q.dir;

    // per-bit mix: driven bits echo the register, others the pin
    always_comb begin
        for (int i = 0; i < int'(W); i++) begin
            rd_o[i] = st_q.dir[i] ? st_q.outr[i] : pin_i[i];
        end
    end

    AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_out |=> $stable(out_o)) else $error("port output changed without write"); // R2
    AST_PORT_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        (((rd_o ^ out_o) & oe_o) == '0) && (((rd_o ^ pin_i) & ~oe_o) == '0))
        else $error("port read mix wrong"); // R4
endmodule

// File: rtl/pia_counter.sv
module pia_counter #(
    parameter int unsigned W        = 8,
    parameter bit          HAS_HLAT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_llo,
    input  logic         wr_lhi,
    input  logic         wr_load,
    input  logic [W-1:0] wdata,
    input  pia_pkg::csel_e rd_sel,
    output logic [W-1:0] rd_o
);
    import pia_pkg::*;
    localparam int unsigned CW = 2 * W;

    typedef struct packed {
        logic [W-1:0]  llo;
        logic [W-1:0]  lhi;
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_llo) st_d.llo = wdata;
        if (HAS_HLAT && (wr_lhi || wr_load)) st_d.lhi = wdata;
        if (wr_load) st_d.cnt = {wdata, st_q.llo};
        else         st_d.cnt = st_q.cnt - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (rd_sel)
            CSEL_CNT_LO: rd_o = st_q.cnt[W-1:0];
            CSEL_CNT_HI: rd_o = st_q.cnt[CW-1:W];
            CSEL_LAT_LO: rd_o = st_q.llo;
            CSEL_LAT_HI: rd_o = st_q.lhi;
            default:     rd_o = '0;
        endcase
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_load |=> st_q.cnt == CW'($past(st_q.cnt) - CW'(1)))
        else $error("counter did not step down"); // R8
    AST_HLAT_KEEP_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lhi |=> st_q.cnt[CW-1:W] == CW'($past(st_q.cnt) - CW'(1)) >> W)
        else $error("high latch write disturbed counter"); // R6
endmodule

// File: rtl/pia_dual_port.sv
module pia_dual_port #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         rd_nwr,
    input  logic [3:0]   rs,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] pa_in,
    output logic [W-1:0] pa_out,
    output logic [W-1:0] pa_oe,
    input  logic [W-1:0] pb_in,
    output logic [W-1:0] pb_out,
    output logic [W-1:0] pb_oe
);
    import pia_pkg::*;

    logic         wr, rd;
    logic         wr_pa_out, wr_pb_out, wr_pa_dir, wr_pb_dir;
    logic         c1_llo, c1_lhi, c1_load, c2_llo, c2_load;
    logic [W-1:0] pa_rd, pb_rd, c1_rd, c2_rd;
    logic [W-1:0] rdata_d;
    csel_e        c1_sel, c2_sel;

    assign wr = sel && !rd_nwr;
    assign rd = sel &&  rd_nwr;

    always_comb begin
        wr_pb_out = wr && (rs == RS_PB);
        wr_pa_out = wr && ((rs == RS_PA) || (rs == RS_PA_ALT));
        wr_pb_dir = wr && (rs == RS_DIRB);
        wr_pa_dir = wr && (rs == RS_DIRA);
        c1_llo    = wr && ((rs == RS_C1_LO) || (rs == RS_C1_LLO));
        c1_lhi    = wr && (rs == RS_C1_LHI);
        c1_load   = wr && (rs == RS_C1_HI);
        c2_llo    = wr && (rs == RS_C2_LO);
        c2_load   = wr && (rs == RS_C2_HI);
    end

    pia_port #(.W(W)) port_a_i (
        .clk(clk), .rst_n(rst_n), .wr_out(wr_pa_out), .wr_dir(wr_pa_dir),
        .wdata(wdata), .pin_i(pa_in), .out_o(pa_out), .oe_o(pa_oe), .rd_o(pa_rd)
    );

    pia_port #(.W(W)) port_b_i (
        .clk(clk), .rst_n(rst_n), .wr_out(wr_pb_out), .wr_dir(wr_pb_dir),
        .wdata(wdata), .pin_i(pb_in), .out_o(pb_out), .oe_o(pb_oe), .rd_o(pb_rd)
    );

    always_comb begin
        unique case (rs)
            RS_C1_HI:  c1_sel = CSEL_CNT_HI;
            RS_C1_LLO: c1_sel = CSEL_LAT_LO;
            RS_C1_LHI: c1_sel = CSEL_LAT_HI;
            default:   c1_sel = CSEL_CNT_LO;
        endcase
        c2_sel = (rs == RS_C2_HI) ? CSEL_CNT_HI : CSEL_CNT_LO;
    end

    pia_counter #(.W(W), .HAS_HLAT(1'b1)) cnt1_i (
        .clk(clk), .rst_n(rst_n), .wr_llo(c1_llo), .wr_lhi(c1_lhi),
        .wr_load(c1_load), .wdata(wdata), .rd_sel(c1_sel), .rd_o(c1_rd)
    );

    pia_counter #(.W(W), .HAS_HLAT(1'b0)) cnt2_i (
        .clk(clk), .rst_n(rst_n), .wr_llo(c2_llo), .wr_lhi(1'b0),
        .wr_load(c2_load), .wdata(wdata), .rd_sel(c2_sel), .rd_o(c2_rd)
    );

    always_comb begin
        rdata_d = '0;
        unique case (rs)
            RS_PB:                    rdata_d = pb_rd;
            RS_PA, RS_PA_ALT:         rdata_d = pa_rd;
            RS_DIRB:                  rdata_d = pb_oe;
            RS_DIRA:                  rdata_d = pa_oe;
            RS_C1_LO, RS_C1_HI,
            RS_C1_LLO, RS_C1_LHI:     rdata_d = c1_rd;
            RS_C2_LO, RS_C2_HI:       rdata_d = c2_rd;
            default:                  rdata_d = '0;
        endcase
    end

    assign rdata = rd ? rdata_d : '0;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> rdata == '0) else $error("read data not idle"); // R11
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && rs >= 4'd10 && rs <= 4'd14) |-> rdata == '0)
        else $error("placeholder read non-zero"); // R10
    AST_SPARE_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rs >= 4'd10 && rs <= 4'd14) |=> ($stable(pa_out) && $stable(pb_out)
            && $stable(pa_oe) && $stable(pb_oe)))
        else $error("placeholder write changed a port"); // R10
    AST_ALIAS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rs == RS_PA_ALT) |=> (pa_out == $past(wdata)))
        else $error("alias write missed port A"); // R5
endmodule

// File: tb/pia_dual_port_tb_top.sv
module pia_dual_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic       rd_nwr = 1'b1;
    logic [3:0] rs = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pa_in = '0, pa_out, pa_oe;
    logic [7:0] pb_in = '0, pb_out, pb_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pia_dual_port dut_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_nwr(rd_nwr), .rs(rs),
        .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out),
        .pa_oe(pa_oe), .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
    );

    // reference state, updated from the requirement text
    logic [7:0]  m_oa, m_ob, m_da, m_db, m_l1lo, m_l1hi, m_l2lo;
    logic [15:0] m_c1, m_c2;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_oa <= 0; m_ob <= 0; m_da <= 0; m_db <= 0;
            m_l1lo <= 0; m_l1hi <= 0; m_l2lo <= 0; m_c1 <= 0; m_c2 <= 0;
        end else begin
            m_c1 <= m_c1 - 16'd1;
            m_c2 <= m_c2 - 16'd1;
            if (sel && !rd_nwr) begin
                case (rs)
                    4'd0: m_ob <= wdata;
                    4'd1, 4'd15: m_oa <= wdata;
                    4'd2: m_db <= wdata;
                    4'd3: m_da <= wdata;
                    4'd4, 4'd6: m_l1lo <= wdata;
                    4'd5: begin m_c1 <= {wdata, m_l1lo}; m_l1hi <= wdata; end
                    4'd7: m_l1hi <= wdata;
                    4'd8: m_l2lo <= wdata;
                    4'd9: m_c2 <= {wdata, m_l2lo};
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] mix(input logic [7:0] o, input logic [7:0] d, input logic [7:0] p);
        return (o & d) | (p & ~d);
    endfunction

    function automatic logic [7:0] exp_rd();
        if (!(sel && rd_nwr)) return 8'h00;
        case (rs)
            4'd0: return mix(m_ob, m_db, pb_in);
            4'd1, 4'd15: return mix(m_oa, m_da, pa_in);
            4'd2: return m_db;
            4'd3: return m_da;
            4'd4: return m_c1[7:0];
            4'd5: return m_c1[15:8];
            4'd6: return m_l1lo;
            4'd7: return m_l1hi;
            4'd8: return m_c2[7:0];
            4'd9: return m_c2[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of();
        if (!(sel && rd_nwr)) return "R11";
        case (rs)
            4'd0, 4'd1: return "R4";
            4'd2, 4'd3: return "R3";
            4'd4, 4'd5: return "R7";
            4'd6, 4'd7: return "R6";
            4'd8, 4'd9: return "R9";
            4'd15: return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus(input logic s, input logic r, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = s; rd_nwr = r; rs = a; wdata = d;
        #1;
        check8(tag_of(), rdata, exp_rd());
        check8("R2", pa_out, m_oa);
        check8("R2", pb_out, m_ob);
        check8("R3", pa_oe, m_da);
        check8("R3", pb_oe, m_db);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        pa_in = 8'h3C; pb_in = 8'hC3;
        repeat (3) @(posedge clk);
        #2;
        check8("R1", pa_out, 8'h00); check8("R1", pa_oe, 8'h00);
        check8("R1", pb_out, 8'h00); check8("R1", pb_oe, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // ports
        bus(1, 0, 4'd3, 8'hF0);
        bus(1, 0, 4'd1, 8'hA5);
        bus(1, 1, 4'd1, 8'h00); check8("R4", rdata, 8'hAC);
        bus(1, 1, 4'd15, 8'h00); check8("R5", rdata, 8'hAC);
        bus(1, 0, 4'd15, 8'h5A);
        bus(1, 1, 4'd1, 8'h00); check8("R5", rdata, 8'h5C);
        bus(1, 0, 4'd2, 8'h0F);
        bus(1, 0, 4'd0, 8'h99);
        bus(1, 1, 4'd0, 8'h00); check8("R4", rdata, 8'hC9);
        bus(1, 1, 4'd2, 8'h00); check8("R3", rdata, 8'h0F);
        // counter 1 load, then read in the following cycles
        bus(1, 0, 4'd4, 8'h34);
        bus(1, 0, 4'd5, 8'h12);
        bus(1, 1, 4'd4, 8'h00); check8("R8", rdata, 8'h34);
        bus(1, 1, 4'd4, 8'h00); check8("R8", rdata, 8'h33);
        bus(1, 1, 4'd5, 8'h00); check8("R7", rdata, 8'h12);
        bus(1, 1, 4'd7, 8'h00); check8("R7", rdata, 8'h12);
        bus(1, 0, 4'd7, 8'h77);
        bus(1, 1, 4'd7, 8'h00); check8("R6", rdata, 8'h77);
        bus(1, 1, 4'd5, 8'h00); check8("R6", rdata, 8'h12);
        bus(1, 0, 4'd6, 8'h00);
        bus(1, 0, 4'd5, 8'h00);
        bus(1, 1, 4'd4, 8'h00); check8("R8", rdata, 8'h00);
        bus(1, 1, 4'd5, 8'h00); check8("R8", rdata, 8'hFF);
        // counter 2
        bus(1, 0, 4'd8, 8'h02);
        bus(1, 0, 4'd9, 8'hAB);
        bus(1, 1, 4'd9, 8'h00); check8("R9", rdata, 8'hAB);
        bus(1, 1, 4'd8, 8'h00); check8("R9", rdata, 8'h01);
        // placeholders
        for (int k = 10; k <= 14; k++) bus(1, 0, 4'(k), 8'hFF);
        for (int k = 10; k <= 14; k++) begin
            bus(1, 1, 4'(k), 8'h00); check8("R10", rdata, 8'h00);
        end
        bus(0, 1, 4'd1, 8'h00); check8("R11", rdata, 8'h00);
        bus(1, 0, 4'd1, 8'h00); check8("R11", rdata, 8'h00);

        for (int n = 0; n < 600; n++) begin
            pa_in = 8'($urandom); pb_in = 8'($urandom);
            bus(($urandom % 8) != 0, 1'($urandom), 4'($urandom), 8'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule